// File: doc/BRIEF.md
# SSA Bytecode Instruction Decoder

This block turns one fetched instruction of a compact SSA-style bytecode into a micro-op code and a set of decoded fields for the core sequencer. An instruction is up to nine bytes long. Byte 0 holds the opcode and byte 1 holds the instruction's own length in bytes. The remaining bytes carry SSA value ids, a 32-bit constant, 16-bit branch targets, or predecessor-edge tags. The block is purely combinational. Register reads, execution and memory access happen elsewhere.

Control-flow instructions carry the tag of the edge they take. A phi merge carries two source/tag pairs, so the sequencer can pick the source whose tag matches the edge it arrived on. The decoder only extracts these fields. The decoder checks that the length byte agrees with the opcode. It flags any opcode it does not know, or any length that does not match, as illegal and suppresses every output.

Top module: `ssa_decoder`

## Requirements
- R1: The opcode byte (byte 0) maps to the micro-op output as follows: 0x01 constant→1, 0x02 add→2, 0x03 sub→3, 0x04 mul→4, 0x05 load→5, 0x06 store→6, 0x07 branch→7, 0x08 jump→8, 0x09 return→9, 0x0A phi→10, 0xFF halt→11. Every other case gives micro-op 0.
- R2: The length byte (byte 1) must equal the opcode's size. The sizes are: constant 7, phi 7, add/sub/mul 5, jump 5, load/store 4, branch 9, return 3, halt 2. Any other length raises `illegal`, and then micro-op, write enable and every field output are 0.
- R3: An opcode outside the set in R1 raises `illegal`, whatever the length byte holds. The outputs are then the same as in R2.
- R4: `writeEn` is 1 exactly for legal constant, add, sub, mul, load and phi instructions.
- R5: Constant: the destination is byte 2. The immediate is bytes 3..6, with byte 3 as the least-significant byte.
- R6: Add/sub/mul: the destination is byte 2, source A is byte 3 and source B is byte 4.
- R7: Load: the destination is byte 2 and source A (the address) is byte 3. Store: source A (the data) is byte 2 and source B (the address) is byte 3.
- R8: Branch: source A (the condition) is byte 2. The taken target is bytes 3..4 and the not-taken target is bytes 5..6, each with the low byte first. Tag A is byte 7 and tag B is byte 8.
- R9: Jump: the taken target is bytes 2..3 with the low byte first, and tag A is byte 4. Return: source A is byte 2.
- R10: Phi: the destination is byte 2, source A is byte 3, source B is byte 4, tag A is byte 5 and tag B is byte 6.
- R11: Any field output that an opcode does not use is 0. Bytes beyond the instruction's length have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instrBytes | input | 72 | Fetched instruction window; byte k sits at bits [8k+7:8k] |
| uop | output | 4 | Micro-op code (R1 encoding) |
| illegal | output | 1 | Unknown opcode or wrong length byte |
| writeEn | output | 1 | Instruction writes its destination SSA id |
| destId | output | 8 | Destination SSA id |
| srcAId | output | 8 | First source SSA id (condition, data or address by opcode) |
| srcBId | output | 8 | Second source SSA id |
| immediate | output | 32 | Constant value |
| takenTarget | output | 16 | Branch-taken or jump target |
| notTakenTarget | output | 16 | Branch fall-back target |
| tagA | output | 8 | First predecessor tag |
| tagB | output | 8 | Second predecessor tag |

## Verification
The hardest situation to reach is a known opcode whose trailing bytes are non-zero but lie past its declared length, or that belong to fields the opcode does not use. A leak from such a byte stays invisible unless every unused byte carries a distinct non-zero value. The bench therefore sweeps all 65,536 combinations of opcode and length byte, with bytes 2..8 filled from a pattern that changes with both. For every legal opcode it then runs a further series of pseudo-random windows. The bench computes the expected fields from the byte layouts alone.

// File: rtl/ssa_decoder_pkg.sv
package ssa_decoder_pkg;
  parameter int BYTE_W   = 8;
  parameter int MAX_LEN  = 9;
  parameter int IMM_W    = 32;
  parameter int TGT_W    = 16;
  localparam int IDX_W     = $clog2(MAX_LEN);
  localparam int IDXP_W    = IDX_W + 1;
  localparam int IMM_BYTES = IMM_W / BYTE_W;
  localparam int TGT_BYTES = TGT_W / BYTE_W;
  localparam int WIN_W     = MAX_LEN * BYTE_W;

  typedef logic [IDX_W-1:0] idx_t;

  typedef enum logic [3:0] {
    UOP_NONE   = 4'd0,
    UOP_CONST  = 4'd1,
    UOP_ADD    = 4'd2,
    UOP_SUB    = 4'd3,
    UOP_MUL    = 4'd4,
    UOP_LOAD   = 4'd5,
    UOP_STORE  = 4'd6,
    UOP_BRANCH = 4'd7,
    UOP_JUMP   = 4'd8,
    UOP_RETURN = 4'd9,
    UOP_PHI    = 4'd10,
    UOP_HALT   = 4'd11
  } uop_e;

  // Strobes from control to datapath: each field has an enable and a start byte.
  typedef struct packed {
    logic destOn;  idx_t destAt;
    logic srcAOn;  idx_t srcAAt;
    logic srcBOn;  idx_t srcBAt;
    logic immOn;   idx_t immAt;
    logic tgtOn;   idx_t tgtAt;
    logic altOn;   idx_t altAt;
    logic tagAOn;  idx_t tagAAt;
    logic tagBOn;  idx_t tagBAt;
  } fieldSel_t;
endpackage

// File: rtl/ssa_decoder_ctrl.sv
module ssa_decoder_ctrl
  import ssa_decoder_pkg::*;
(
  input  logic [BYTE_W-1:0] opcode,
  input  logic [BYTE_W-1:0] lenByte,
  output uop_e              uop,
  output logic              illegal,
  output logic              writeEn,
  output fieldSel_t         sel
);
  uop_e              rawUop;
  logic [BYTE_W-1:0] reqLen;
  logic              rawWr;
  fieldSel_t         rawSel;

  always_comb begin
    rawUop = UOP_NONE;
    reqLen = '0;
    rawWr  = 1'b0;
    rawSel = '0;
    unique case (opcode)
      8'h01: begin
        rawUop = UOP_CONST; reqLen = 8'd7; rawWr = 1'b1;
        rawSel.destOn = 1'b1; rawSel.destAt = idx_t'(2);
        rawSel.immOn  = 1'b1; rawSel.immAt  = idx_t'(3);
      end
      8'h02, 8'h03, 8'h04: begin
        rawUop = (opcode == 8'h02) ? UOP_ADD : (opcode == 8'h03) ? UOP_SUB : UOP_MUL;
        reqLen = 8'd5; rawWr = 1'b1;
        rawSel.destOn = 1'b1; rawSel.destAt = idx_t'(2);
        rawSel.srcAOn = 1'b1; rawSel.srcAAt = idx_t'(3);
        rawSel.srcBOn = 1'b1; rawSel.srcBAt = idx_t'(4);
      end
      8'h05: begin
        rawUop = UOP_LOAD; reqLen = 8'd4; rawWr = 1'b1;
        rawSel.destOn = 1'b1; rawSel.destAt = idx_t'(2);
        rawSel.srcAOn = 1'b1; rawSel.srcAAt = idx_t'(3);
      end
      8'h06: begin
        rawUop = UOP_STORE; reqLen = 8'd4;
        rawSel.srcAOn = 1'b1; rawSel.srcAAt = idx_t'(2);
        rawSel.srcBOn = 1'b1; rawSel.srcBAt = idx_t'(3);
      end
      8'h07: begin
        rawUop = UOP_BRANCH; reqLen = 8'd9;
        rawSel.srcAOn = 1'b1; rawSel.srcAAt = idx_t'(2);
        rawSel.tgtOn  = 1'b1; rawSel.tgtAt  = idx_t'(3);
        rawSel.altOn  = 1'b1; rawSel.altAt  = idx_t'(5);
        rawSel.tagAOn = 1'b1; rawSel.tagAAt = idx_t'(7);
        rawSel.tagBOn = 1'b1; rawSel.tagBAt = idx_t'(8);
      end
      8'h08: begin
        rawUop = UOP_JUMP; reqLen = 8'd5;
        rawSel.tgtOn  = 1'b1; rawSel.tgtAt  = idx_t'(2);
        rawSel.tagAOn = 1'b1; rawSel.tagAAt = idx_t'(4);
      end
      8'h09: begin
        rawUop = UOP_RETURN; reqLen = 8'd3;
        rawSel.srcAOn = 1'b1; rawSel.srcAAt = idx_t'(2);
      end
      8'h0A: begin
        rawUop = UOP_PHI; reqLen = 8'd7; rawWr = 1'b1;
        rawSel.destOn = 1'b1; rawSel.destAt = idx_t'(2);
        rawSel.srcAOn = 1'b1; rawSel.srcAAt = idx_t'(3);
        rawSel.srcBOn = 1'b1; rawSel.srcBAt = idx_t'(4);
        rawSel.tagAOn = 1'b1; rawSel.tagAAt = idx_t'(5);
        rawSel.tagBOn = 1'b1; rawSel.tagBAt = idx_t'(6);
      end
      8'hFF: begin
        rawUop = UOP_HALT; reqLen = 8'd2;
      end
      default: ;
    endcase
  end

  // Any unknown opcode or size mismatch squashes everything.
  always_comb begin
    illegal = (rawUop == UOP_NONE) || (lenByte != reqLen);
    uop     = illegal ? UOP_NONE : rawUop;
    writeEn = !illegal && rawWr;
    sel     = illegal ? '0 : rawSel;
  end

  // R2: a legal instruction never reaches beyond the fetch window.
  always_comb begin
    if (!illegal)
      a_r2_len_in_window: assert (int'(lenByte) <= MAX_LEN && int'(lenByte) >= 2)
        else $error("legal length outside window");
  end
endmodule

// File: rtl/ssa_decoder_datapath.sv
module ssa_decoder_datapath
  import ssa_decoder_pkg::*;
(
  input  logic [WIN_W-1:0]  window,
  input  fieldSel_t         sel,
  output logic [BYTE_W-1:0] destId,
  output logic [BYTE_W-1:0] srcAId,
  output logic [BYTE_W-1:0] srcBId,
  output logic [IMM_W-1:0]  immediate,
  output logic [TGT_W-1:0]  takenTarget,
  output logic [TGT_W-1:0]  notTakenTarget,
  output logic [BYTE_W-1:0] tagA,
  output logic [BYTE_W-1:0] tagB
);
  function automatic logic [BYTE_W-1:0] pick(input logic [IDXP_W-1:0] idx);
    if (int'(idx) < MAX_LEN) return window[int'(idx)*BYTE_W +: BYTE_W];
    return '0;
  endfunction

  assign destId = sel.destOn ? pick({1'b0, sel.destAt}) : '0;
  assign srcAId = sel.srcAOn ? pick({1'b0, sel.srcAAt}) : '0;
  assign srcBId = sel.srcBOn ? pick({1'b0, sel.srcBAt}) : '0;
  assign tagA   = sel.tagAOn ? pick({1'b0, sel.tagAAt}) : '0;
  assign tagB   = sel.tagBOn ? pick({1'b0, sel.tagBAt}) : '0;

  // Multi-byte fields are little-endian: lowest byte index is least significant.
  for (genvar k = 0; k < IMM_BYTES; k++) begin : g_imm
    assign immediate[k*BYTE_W +: BYTE_W] =
      sel.immOn ? pick({1'b0, sel.immAt} + IDXP_W'(k)) : '0;
  end
  for (genvar k = 0; k < TGT_BYTES; k++) begin : g_tgt
    assign takenTarget[k*BYTE_W +: BYTE_W] =
      sel.tgtOn ? pick({1'b0, sel.tgtAt} + IDXP_W'(k)) : '0;
    assign notTakenTarget[k*BYTE_W +: BYTE_W] =
      sel.altOn ? pick({1'b0, sel.altAt} + IDXP_W'(k)) : '0;
  end
endmodule

// File: rtl/ssa_decoder.sv
module ssa_decoder
  import ssa_decoder_pkg::*;
(
  input  logic [71:0] instrBytes,
  output logic [3:0]  uop,
  output logic        illegal,
  output logic        writeEn,
  output logic [7:0]  destId,
  output logic [7:0]  srcAId,
  output logic [7:0]  srcBId,
  output logic [31:0] immediate,
  output logic [15:0] takenTarget,
  output logic [15:0] notTakenTarget,
  output logic [7:0]  tagA,
  output logic [7:0]  tagB
);
  uop_e      uopE;
  fieldSel_t sel;

  ssa_decoder_ctrl uCtrl (
    .opcode  (instrBytes[7:0]),
    .lenByte (instrBytes[15:8]),
    .uop     (uopE),
    .illegal (illegal),
    .writeEn (writeEn),
    .sel     (sel)
  );

  ssa_decoder_datapath uPath (
    .window         (instrBytes),
    .sel            (sel),
    .destId         (destId),
    .srcAId         (srcAId),
    .srcBId         (srcBId),
    .immediate      (immediate),
    .takenTarget    (takenTarget),
    .notTakenTarget (notTakenTarget),
    .tagA           (tagA),
    .tagB           (tagB)
  );

  assign uop = uopE;

  // Cross-checks between control outcome and datapath fields.
  always_comb begin
    if (illegal)
      a_r2_squash_fields: assert ({destId, srcAId, srcBId, immediate, takenTarget,
                                   notTakenTarget, tagA, tagB} == '0 && !writeEn)
        else $error("illegal instruction leaked fields");
    if (writeEn)
      a_r4_dest_from_byte2: assert (destId == instrBytes[23:16])
        else $error("write enable without destination at byte 2");
    if (uopE == UOP_CONST)
      a_r5_imm_le: assert (immediate == instrBytes[55:24])
        else $error("constant not little-endian from byte 3");
    if (uopE == UOP_BRANCH)
      a_r8_branch_tags: assert (tagA == instrBytes[63:56] && tagB == instrBytes[71:64])
        else $error("branch tags misplaced");
    if (uopE == UOP_JUMP)
      a_r9_jump_fields: assert (takenTarget == instrBytes[31:16] && tagB == '0
                                && notTakenTarget == '0)
        else $error("jump fields misplaced");
  end
endmodule

// File: tb/ssa_decoder_test.sv
module ssa_decoder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [71:0] instrBytes = '0;
  logic [3:0]  uop;
  logic        illegal, writeEn;
  logic [7:0]  destId, srcAId, srcBId, tagA, tagB;
  logic [31:0] immediate;
  logic [15:0] takenTarget, notTakenTarget;

  ssa_decoder uut (
    .instrBytes(instrBytes), .uop(uop), .illegal(illegal), .writeEn(writeEn),
    .destId(destId), .srcAId(srcAId), .srcBId(srcBId), .immediate(immediate),
    .takenTarget(takenTarget), .notTakenTarget(notTakenTarget),
    .tagA(tagA), .tagB(tagB)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int cycles = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int sizeOf(input logic [7:0] op);
    case (op)
      8'h01, 8'h0A: return 7;
      8'h02, 8'h03, 8'h04, 8'h08: return 5;
      8'h05, 8'h06: return 4;
      8'h07: return 9;
      8'h09: return 3;
      8'hFF: return 2;
      default: return -1;
    endcase
  endfunction

  function automatic logic [3:0] uopOf(input logic [7:0] op);
    if (op == 8'hFF) return 4'd11;
    if (op >= 8'h01 && op <= 8'h0A) return op[3:0];
    return 4'd0;
  endfunction

  task automatic runCase(input logic [71:0] w);
    logic [7:0] b [9];
    logic [7:0] op;
    bit legal;
    logic [7:0] eD, eA, eB, eTA, eTB;
    logic [31:0] eI;
    logic [15:0] eT, eN;
    for (int k = 0; k < 9; k++) b[k] = w[k*8 +: 8];
    op = b[0];
    legal = (sizeOf(op) >= 0) && (int'(b[1]) == sizeOf(op));
    {eD, eA, eB, eTA, eTB, eI, eT, eN} = '0;
    if (legal) begin
      case (op)
        8'h01: begin eD = b[2]; eI = {b[6], b[5], b[4], b[3]}; end          // R5
        8'h02, 8'h03, 8'h04: begin eD = b[2]; eA = b[3]; eB = b[4]; end     // R6
        8'h05: begin eD = b[2]; eA = b[3]; end                              // R7
        8'h06: begin eA = b[2]; eB = b[3]; end                              // R7
        8'h07: begin eA = b[2]; eT = {b[4], b[3]}; eN = {b[6], b[5]};
                     eTA = b[7]; eTB = b[8]; end                            // R8
        8'h08: begin eT = {b[3], b[2]}; eTA = b[4]; end                     // R9
        8'h09: eA = b[2];                                                   // R9
        8'h0A: begin eD = b[2]; eA = b[3]; eB = b[4]; eTA = b[5]; eTB = b[6]; end // R10
        default: ;
      endcase
    end
    instrBytes = w;
    #1;
    if (sizeOf(op) < 0) chk("R3", 64'(illegal), 64'(1));
    else chk("R2", 64'(illegal), 64'(!legal));
    chk("R1", 64'(uop), legal ? 64'(uopOf(op)) : 64'(0));
    chk("R4", 64'(writeEn),
        64'(legal && (op == 8'h01 || op == 8'h02 || op == 8'h03 || op == 8'h04 ||
                      op == 8'h05 || op == 8'h0A)));
    chk("R11 ids/tags", {24'(0), destId, srcAId, srcBId, tagA, tagB},
        {24'(0), eD, eA, eB, eTA, eTB});
    chk("R11 imm/targets", {immediate, takenTarget, notTakenTarget}, {eI, eT, eN});
  endtask

  initial begin
    logic [31:0] lfsr;
    logic [7:0] ops [11];
    ops = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'hFF};
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset-like idle state: an all-zero window is an unknown opcode.
    chk("R3 idle", 64'(illegal), 64'(1));
    chk("R1 idle", 64'(uop), 64'(0));
    // Exhaustive opcode x length sweep with distinct non-zero trailing bytes.
    for (int op = 0; op < 256; op++) begin
      for (int len = 0; len < 256; len++) begin
        logic [71:0] w;
        w[7:0] = 8'(op);
        w[15:8] = 8'(len);
        for (int k = 2; k < 9; k++) w[k*8 +: 8] = 8'(op * 7 + len * 13 + k * 29 + 1) | 8'h01;
        runCase(w);
      end
    end
    // Pseudo-random payloads for every legal opcode with its correct length.
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 11; i++) begin
      for (int r = 0; r < 200; r++) begin
        logic [71:0] w;
        for (int k = 2; k < 9; k++) begin
          lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
          w[k*8 +: 8] = lfsr[7:0];
        end
        w[7:0] = ops[i];
        w[15:8] = 8'(sizeOf(ops[i]));
        runCase(w);
      end
    end
    // Explicit corner: constant 0x0C0B0A09 with junk after its length (R5, R11).
    runCase({8'hEE, 8'hDD, 8'h0C, 8'h0B, 8'h0A, 8'h09, 8'h21, 8'h07, 8'h01});
    chk("R5 literal", 64'(immediate), 64'h0C0B0A09);
    // Explicit corner: branch targets 0x1234 / 0x5678 (R8).
    runCase({8'h99, 8'h88, 8'h56, 8'h78, 8'h12, 8'h34, 8'h05, 8'h09, 8'h07});
    chk("R8 literal", {32'(0), takenTarget, notTakenTarget}, 64'h1234_5678);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    if (!rst && !done) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end
endmodule